// File: doc/BRIEF.md
# Masked BSSID and Multicast Receive Filter

This block decides, for every received frame header, whether the frame is accepted and whether it may be acknowledged. Software programs the station address, the BSSID, the BSSID compare mask, a 64-bit group-address hash filter, an 8-bit frame-class filter word and a receive-disable bit over a simple 32-bit register bus. The parser ahead of the block presents the destination address, the BSSID field and a 3-bit frame class with a one-cycle strobe.

The BSSID comparison only looks at the bit positions where the mask holds a one. A single station address can therefore answer for several virtual BSSes. Frames from outside the intended set can also pass if they agree on the compared bits, and the block allows this. The group filter can be loaded one whole word at a time, or changed one bit at a time by index.

A three-state sequencer handles each header. In S_IDLE, `hdr_ready` is high. A strobe in S_IDLE captures the header and takes the transition IDLE->EVAL. In S_EVAL the decision is computed and registered, then the unconditional transition EVAL->DONE follows. In S_DONE, `dec_valid` is high with the result, then the unconditional transition DONE->IDLE follows.

Top module: `rx_match_filter`

## Requirements
- R1: Register map (word addresses): 0 station low 32 bits, 1 station high 16 bits, 2 BSSID low, 3 BSSID high (bits 15:0 address, bits 29:16 association ID), 4 mask low, 5 mask high, 6 class filter (bits 7:0), 7 control (bit 0 receive disable), 8 group filter word 0, 9 group filter word 1. Address bit k of a 48-bit value sits in bit k of the low word for k<32, and in bit k-32 of the high word otherwise. Reads return the stored fields, and unused bits read as 0.
- R2: A write to the BSSID high word sets all 48 mask bits to 1. A later mask write overrides this.
- R3: The BSSID check passes when ((frame BSSID XOR station) AND mask) is zero. For example, station 0x10 with mask 0x20 passes BSSID 0xD0 and fails BSSID 0x60.
- R4: A destination is unicast when its bit 0 is 0. A unicast frame is address-eligible only when the destination equals the station address and the BSSID check passes. `ack_ok` is 1 exactly when the frame is accepted and is such a unicast hit.
- R5: A destination with bit 0 set is a group address. Its hash index is the XOR of the eight 6-bit slices (bits 5:0, 11:6, …, 47:42), and it is address-eligible when that group filter bit is 1.
- R6: Group filter bit i lies in word 0 bit i for i<32, and in word 1 bit i-32 otherwise. `idx_set` sets bit `idx_val` and `idx_clr` clears it. If both are asserted, the clear wins. A bus write to a group filter word in the same cycle wins over an index command.
- R7: An index command with `idx_val` of 64 or above leaves the group filter unchanged.
- R8: A frame is accepted when class filter bit [`hdr_cls`] is 1 and the frame is address-eligible. If bit 7 (promiscuous) is 1, every frame is accepted. Only 8 bits of the class filter are stored.
- R9: While the receive-disable bit is 1, `accept` and `ack_ok` are both 0.
- R10: A strobe sampled while `hdr_ready` is high gives `dec_valid` for exactly one cycle, two clock edges later. `hdr_ready` is low while a header is being evaluated and reported.
- R11: After reset, the mask is all ones and the station address, BSSID, association ID, group filter, class filter and receive-disable bit are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| idx_set | input | 1 | Set one group filter bit |
| idx_clr | input | 1 | Clear one group filter bit |
| idx_val | input | 8 | Group filter bit index |
| hdr_valid | input | 1 | Header strobe |
| hdr_ready | output | 1 | Sequencer idle, header can be taken |
| hdr_da | input | 48 | Destination address, first octet in bits 7:0 |
| hdr_bssid | input | 48 | BSSID field of the frame |
| hdr_cls | input | 3 | Frame class, selects a class filter bit |
| dec_valid | output | 1 | Decision valid |
| accept | output | 1 | Frame accepted |
| ack_ok | output | 1 | Frame eligible for acknowledgement |

## Verification
The assertions check on every cycle that:
- the strobe and result handshake never overlaps and lasts one cycle,
- an acknowledge never appears without acceptance,
- receive disable suppresses both flags,
- an association write opens the mask fully,
- an out-of-range index leaves the group filter untouched.

Only the bench's scenarios can show that the masked comparison, the hash bit selection, the class filter and promiscuous bit, and the index-to-word mapping give the right decisions. The bench checks these against its own model, using random addresses and masks plus directed edge cases.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int ADDR_W      = 48;
    localparam int DATA_W      = 32;
    localparam int HI_W        = ADDR_W - DATA_W;
    localparam int AID_W       = 14;
    localparam int MC_BITS     = 64;
    localparam int MC_IDX_W    = $clog2(MC_BITS);
    localparam int MC_WORDS    = MC_BITS / DATA_W;
    localparam int IDX_IN_W    = 8;
    localparam int TF_W        = 8;
    localparam int CLS_W       = $clog2(TF_W);
    localparam int PROMISC_BIT = TF_W - 1;
    localparam int HASH_W      = MC_IDX_W;
    localparam int HASH_SLICES = ADDR_W / HASH_W;
    localparam int REG_AW      = 4;

    localparam logic [REG_AW-1:0] REG_STA_LO  = 4'd0;
    localparam logic [REG_AW-1:0] REG_STA_HI  = 4'd1;
    localparam logic [REG_AW-1:0] REG_BSS_LO  = 4'd2;
    localparam logic [REG_AW-1:0] REG_BSS_HI  = 4'd3;
    localparam logic [REG_AW-1:0] REG_MASK_LO = 4'd4;
    localparam logic [REG_AW-1:0] REG_MASK_HI = 4'd5;
    localparam logic [REG_AW-1:0] REG_CLASS   = 4'd6;
    localparam logic [REG_AW-1:0] REG_CTRL    = 4'd7;
    localparam int                REG_MC_BASE = 8;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EVAL = 2'd1,
        S_DONE = 2'd2
    } dec_state_t;
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
    import rxf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_AW-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [REG_AW-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                idx_set,
    input  logic                idx_clr,
    input  logic [IDX_IN_W-1:0] idx_val,
    output logic [ADDR_W-1:0]   sta_o,
    output logic [ADDR_W-1:0]   mask_o,
    output logic [MC_BITS-1:0]  mc_o,
    output logic [TF_W-1:0]     tf_o,
    output logic                rx_dis_o
);
    logic [ADDR_W-1:0]  sta_q, bss_q, mask_q;
    logic [AID_W-1:0]   aid_q;
    logic [MC_BITS-1:0] mc_q, mc_nxt;
    logic [TF_W-1:0]    tf_q;
    logic               dis_q;
    logic               idx_ok, mc_bus_wr;

    assign idx_ok = (idx_val < IDX_IN_W'(MC_BITS));

    // Group filter next value: index command first, bus word write overrides.
    always_comb begin
        mc_nxt    = mc_q;
        mc_bus_wr = 1'b0;
        if (idx_ok) begin
            if (idx_set) mc_nxt[idx_val[MC_IDX_W-1:0]] = 1'b1;
            if (idx_clr) mc_nxt[idx_val[MC_IDX_W-1:0]] = 1'b0;
        end
        for (int w = 0; w < MC_WORDS; w++) begin
            if (wr_en && wr_addr == REG_AW'(REG_MC_BASE + w)) begin
                mc_nxt[w*DATA_W +: DATA_W] = wr_data;
                mc_bus_wr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sta_q  <= '0;
            bss_q  <= '0;
            aid_q  <= '0;
            mask_q <= '1;
            mc_q   <= '0;
            tf_q   <= '0;
            dis_q  <= 1'b0;
        end else begin
            mc_q <= mc_nxt;
            if (wr_en) begin
                case (wr_addr)
                    REG_STA_LO:  sta_q[DATA_W-1:0]       <= wr_data;
                    REG_STA_HI:  sta_q[ADDR_W-1:DATA_W]  <= wr_data[HI_W-1:0];
                    REG_BSS_LO:  bss_q[DATA_W-1:0]       <= wr_data;
                    REG_BSS_HI: begin
                        bss_q[ADDR_W-1:DATA_W] <= wr_data[HI_W-1:0];
                        aid_q                  <= wr_data[HI_W +: AID_W];
                        mask_q                 <= '1;
                    end
                    REG_MASK_LO: mask_q[DATA_W-1:0]      <= wr_data;
                    REG_MASK_HI: mask_q[ADDR_W-1:DATA_W] <= wr_data[HI_W-1:0];
                    REG_CLASS:   tf_q                    <= wr_data[TF_W-1:0];
                    REG_CTRL:    dis_q                   <= wr_data[0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_STA_LO:  rd_data = sta_q[DATA_W-1:0];
            REG_STA_HI:  rd_data[HI_W-1:0] = sta_q[ADDR_W-1:DATA_W];
            REG_BSS_LO:  rd_data = bss_q[DATA_W-1:0];
            REG_BSS_HI: begin
                rd_data[HI_W-1:0]     = bss_q[ADDR_W-1:DATA_W];
                rd_data[HI_W +: AID_W] = aid_q;
            end
            REG_MASK_LO: rd_data = mask_q[DATA_W-1:0];
            REG_MASK_HI: rd_data[HI_W-1:0] = mask_q[ADDR_W-1:DATA_W];
            REG_CLASS:   rd_data[TF_W-1:0] = tf_q;
            REG_CTRL:    rd_data[0] = dis_q;
            default: ;
        endcase
        for (int w = 0; w < MC_WORDS; w++) begin
            if (rd_addr == REG_AW'(REG_MC_BASE + w)) rd_data = mc_q[w*DATA_W +: DATA_W];
        end
    end

    assign sta_o    = sta_q;
    assign mask_o   = mask_q;
    assign mc_o     = mc_q;
    assign tf_o     = tf_q;
    assign rx_dis_o = dis_q;

    // Association write opens the mask completely (R2).
    p_assoc_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_BSS_HI) |=> (mask_o == '1));

    // Out-of-range index with no word write keeps the filter (R7).
    p_idx_oob_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((idx_set || idx_clr) && !idx_ok && !mc_bus_wr) |=> $stable(mc_o));
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hdr_valid,
    input  logic [ADDR_W-1:0]  hdr_da,
    input  logic [ADDR_W-1:0]  hdr_bssid,
    input  logic [CLS_W-1:0]   hdr_cls,
    input  logic [ADDR_W-1:0]  sta,
    input  logic [ADDR_W-1:0]  mask,
    input  logic [MC_BITS-1:0] mc,
    input  logic [TF_W-1:0]    tf,
    input  logic               rx_dis,
    output logic               hdr_ready,
    output logic               dec_valid,
    output logic               accept,
    output logic               ack_ok
);
    dec_state_t        state_q, state_d;
    logic [ADDR_W-1:0] da_q, bss_q;
    logic [CLS_W-1:0]  cls_q;
    logic              acc_q, ack_q, acc_d, ack_d;
    logic              is_group, bss_ok, uni_hit, grp_hit, addr_ok;
    logic [HASH_W-1:0] hash;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (hdr_valid) state_d = S_EVAL;
            S_EVAL:  state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        hash = '0;
        for (int s = 0; s < HASH_SLICES; s++) hash ^= da_q[s*HASH_W +: HASH_W];
        is_group = da_q[0];
        bss_ok   = (((bss_q ^ sta) & mask) == '0);
        uni_hit  = !is_group && (da_q == sta) && bss_ok;
        grp_hit  = mc[hash];
        addr_ok  = is_group ? grp_hit : uni_hit;
        acc_d    = !rx_dis && (tf[PROMISC_BIT] || (tf[cls_q] && addr_ok));
        ack_d    = acc_d && uni_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            da_q    <= '0;
            bss_q   <= '0;
            cls_q   <= '0;
            acc_q   <= 1'b0;
            ack_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && hdr_valid) begin
                da_q  <= hdr_da;
                bss_q <= hdr_bssid;
                cls_q <= hdr_cls;
            end
            if (state_q == S_EVAL) begin
                acc_q <= acc_d;
                ack_q <= ack_d;
            end
        end
    end

    always_comb begin
        hdr_ready = (state_q == S_IDLE);
        dec_valid = (state_q == S_DONE);
        accept    = dec_valid && acc_q;
        ack_ok    = dec_valid && ack_q;
    end

    p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr_ready && dec_valid));
    p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);
    p_ack_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ok |-> accept);
    p_rx_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EVAL && rx_dis) |=> (!accept && !ack_ok));
endmodule

// File: rtl/rx_match_filter.sv
module rx_match_filter
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [3:0]  rd_addr,
    output logic [31:0] rd_data,
    input  logic        idx_set,
    input  logic        idx_clr,
    input  logic [7:0]  idx_val,
    input  logic        hdr_valid,
    output logic        hdr_ready,
    input  logic [47:0] hdr_da,
    input  logic [47:0] hdr_bssid,
    input  logic [2:0]  hdr_cls,
    output logic        dec_valid,
    output logic        accept,
    output logic        ack_ok
);
    logic [ADDR_W-1:0]  sta_w, mask_w;
    logic [MC_BITS-1:0] mc_w;
    logic [TF_W-1:0]    tf_w;
    logic               dis_w;

    rxf_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .idx_set  (idx_set),
        .idx_clr  (idx_clr),
        .idx_val  (idx_val),
        .sta_o    (sta_w),
        .mask_o   (mask_w),
        .mc_o     (mc_w),
        .tf_o     (tf_w),
        .rx_dis_o (dis_w)
    );

    rxf_decide u_decide (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_valid (hdr_valid),
        .hdr_da    (hdr_da),
        .hdr_bssid (hdr_bssid),
        .hdr_cls   (hdr_cls),
        .sta       (sta_w),
        .mask      (mask_w),
        .mc        (mc_w),
        .tf        (tf_w),
        .rx_dis    (dis_w),
        .hdr_ready (hdr_ready),
        .dec_valid (dec_valid),
        .accept    (accept),
        .ack_ok    (ack_ok)
    );
endmodule

// File: tb/rx_match_filter_test.sv
module rx_match_filter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        idx_set = 1'b0, idx_clr = 1'b0;
    logic [7:0]  idx_val = '0;
    logic        hdr_valid = 1'b0;
    logic        hdr_ready;
    logic [47:0] hdr_da = '0, hdr_bssid = '0;
    logic [2:0]  hdr_cls = '0;
    logic        dec_valid, accept, ack_ok;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    // Shadow of programmed state
    logic [47:0] m_sta = '0, m_bss = '0, m_mask = '1;
    logic [13:0] m_aid = '0;
    logic [63:0] m_mc = '0;
    logic [7:0]  m_tf = '0;
    logic        m_dis = 1'b0;

    rx_match_filter uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_hash(input logic [47:0] a);
        logic [5:0] h = '0;
        for (int i = 0; i < 8; i++) h ^= a[i*6 +: 6];
        return h;
    endfunction

    function automatic logic [1:0] ref_decide(input logic [47:0] da, input logic [47:0] bs, input logic [2:0] c);
        logic grp, uni, elig, acc;
        grp  = da[0];
        uni  = !grp && (da == m_sta) && (((bs ^ m_sta) & m_mask) == '0);
        elig = grp ? m_mc[ref_hash(da)] : uni;
        acc  = !m_dis && (m_tf[7] || (m_tf[c] && elig));
        return {acc, acc && uni};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            4'd0: m_sta[31:0]  = d;
            4'd1: m_sta[47:32] = d[15:0];
            4'd2: m_bss[31:0]  = d;
            4'd3: begin m_bss[47:32] = d[15:0]; m_aid = d[29:16]; m_mask = '1; end
            4'd4: m_mask[31:0]  = d;
            4'd5: m_mask[47:32] = d[15:0];
            4'd6: m_tf  = d[7:0];
            4'd7: m_dis = d[0];
            4'd8: m_mc[31:0]  = d;
            4'd9: m_mc[63:32] = d;
            default: ;
        endcase
    endtask

    task automatic idx_cmd(input bit s, input bit c, input logic [7:0] i);
        @(negedge clk);
        idx_set = s; idx_clr = c; idx_val = i;
        @(negedge clk);
        idx_set = 1'b0; idx_clr = 1'b0;
        if (i < 64) begin
            if (s) m_mc[i[5:0]] = 1'b1;
            if (c) m_mc[i[5:0]] = 1'b0;
        end
    endtask

    task automatic chk_rd(input string req, input logic [3:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(req, {32'd0, rd_data}, {32'd0, exp});
    endtask

    task automatic hdr(input string req, input logic [47:0] da, input logic [47:0] bs, input logic [2:0] c);
        logic [1:0] e;
        e = ref_decide(da, bs, c);
        @(negedge clk);
        check({req, " ready"}, {63'd0, hdr_ready}, 64'd1);
        hdr_valid = 1'b1; hdr_da = da; hdr_bssid = bs; hdr_cls = c;
        @(negedge clk);
        hdr_valid = 1'b0;
        check("R10 eval", {62'd0, hdr_ready, dec_valid}, 64'd0);
        @(negedge clk);
        check({req, " decision"}, {61'd0, dec_valid, accept, ack_ok}, {61'd0, 1'b1, e});
        @(negedge clk);
        check("R10 release", {62'd0, hdr_ready, dec_valid}, 64'd2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        chk_rd("R11 sta lo", 4'd0, 32'h0);
        chk_rd("R11 bss hi", 4'd3, 32'h0);
        chk_rd("R11 mask lo", 4'd4, 32'hFFFF_FFFF);
        chk_rd("R11 mask hi", 4'd5, 32'h0000_FFFF);
        chk_rd("R11 class", 4'd6, 32'h0);
        chk_rd("R11 ctrl", 4'd7, 32'h0);
        chk_rd("R11 mc0", 4'd8, 32'h0);
        chk_rd("R11 mc1", 4'd9, 32'h0);
        check("R11 outputs", {61'd0, hdr_ready, dec_valid, accept}, 64'd4);

        // R1 field packing
        wr(4'd1, 32'hFFFF_1234);
        chk_rd("R1 sta hi", 4'd1, 32'h0000_1234);
        wr(4'd4, 32'h0);
        wr(4'd3, 32'hFFFF_ABCD);
        chk_rd("R1 bss hi aid", 4'd3, 32'h3FFF_ABCD);
        chk_rd("R2 mask lo after assoc", 4'd4, 32'hFFFF_FFFF);
        wr(4'd6, 32'h0000_01FF);
        chk_rd("R8 class 8 bits", 4'd6, 32'h0000_00FF);

        // R3 masked example
        wr(4'd0, 32'h10); wr(4'd1, 32'h0);
        wr(4'd2, 32'h0);  wr(4'd3, 32'h0);
        wr(4'd4, 32'h20); wr(4'd5, 32'h0);
        wr(4'd6, 32'h01);
        hdr("R3 masked pass", 48'h10, 48'hD0, 3'd0);
        check("R3 pass value", {62'd0, accept, ack_ok}, 64'd0); // sampled after release
        hdr("R3 masked fail", 48'h10, 48'h60, 3'd0);
        hdr("R4 wrong dest", 48'h12, 48'hD0, 3'd0);
        hdr("R8 class off", 48'h10, 48'hD0, 3'd1);

        // R6 / R7 index commands
        idx_cmd(1, 0, 8'd5);
        chk_rd("R6 set low", 4'd8, 32'h20);
        idx_cmd(1, 0, 8'd40);
        chk_rd("R6 set high", 4'd9, 32'h100);
        idx_cmd(0, 1, 8'd5);
        chk_rd("R6 clear low", 4'd8, 32'h0);
        idx_cmd(1, 1, 8'd40);
        chk_rd("R6 clear wins", 4'd9, 32'h0);
        idx_cmd(1, 0, 8'd64);
        chk_rd("R7 oob w0", 4'd8, 32'h0);
        chk_rd("R7 oob w1", 4'd9, 32'h0);
        idx_cmd(1, 0, 8'd200);
        chk_rd("R7 oob 200", 4'd9, 32'h0);

        // R5 group hash: broadcast hashes to 0
        hdr("R5 bcast miss", 48'hFFFF_FFFF_FFFF, 48'h0, 3'd0);
        idx_cmd(1, 0, 8'd0);
        hdr("R5 bcast hit", 48'hFFFF_FFFF_FFFF, 48'h0, 3'd0);
        hdr("R5 group hash", 48'h0000_0000_0041, 48'h0, 3'd0);
        idx_cmd(1, 0, {2'b00, ref_hash(48'h0000_0000_0041)});
        hdr("R5 group hash set", 48'h0000_0000_0041, 48'h0, 3'd0);

        // R8 promiscuous, R9 disable
        wr(4'd6, 32'h80);
        hdr("R8 promisc", 48'h0000_0000_5554, 48'h1234, 3'd2);
        hdr("R8 promisc own", 48'h10, 48'hD0, 3'd2);
        wr(4'd7, 32'h1);
        hdr("R9 disabled", 48'h10, 48'hD0, 3'd2);
        wr(4'd7, 32'h0);

        // Constrained random mix (R3 R4 R5 R8 R9)
        for (int n = 0; n < 400; n++) begin
            logic [47:0] da, bs;
            logic [2:0]  c;
            if (n % 25 == 0) begin
                wr(4'd0, $urandom & 32'hFFFF_FFFE);
                wr(4'd1, $urandom);
                wr(4'd2, $urandom);
                wr(4'd3, $urandom);
                if ($urandom % 4 != 0) begin
                    wr(4'd4, $urandom | $urandom);
                    wr(4'd5, $urandom | $urandom);
                end
                wr(4'd8, $urandom);
                wr(4'd9, $urandom);
                wr(4'd6, ($urandom % 8 == 0) ? $urandom : ($urandom & 32'h7F));
                wr(4'd7, ($urandom % 10 == 0) ? 32'h1 : 32'h0);
            end
            case ($urandom % 4)
                0, 1:    da = m_sta;
                2:       da = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFE;
                default: da = {$urandom, $urandom} | 48'h1;
            endcase
            bs = ($urandom % 2 == 1) ? (m_bss ^ ({$urandom, $urandom} & ~m_mask))
                                     : (m_sta ^ ({$urandom, $urandom} & ~m_mask));
            if ($urandom % 5 == 0) bs = {$urandom, $urandom};
            c = 3'($urandom % 8);
            hdr("R4 random", da, bs, c);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule